// File: doc/BRIEF.md
# Pipeline Exception Status Control

This block follows a small status code alongside every instruction as it flows through a five-stage pipeline. The stages are fetch, decode, execute, memory and writeback. Fetch classifies each instruction from three error flags. Decode and execute carry the code forward unchanged. The memory stage may overwrite it when the data access faults. An exception becomes architecturally visible only once the offending instruction is in writeback. At that point the processor stops: the writeback register freezes and every younger instruction is squashed.

The same status codes gate side effects in the younger stages, in the very cycle they are seen:

- An ALU operation in execute may not write the condition codes while an older instruction in memory or writeback is faulting.
- The memory stage is filled with bubbles from the moment a fault is seen there.
- A data memory write is allowed only for an instruction whose memory-stage status is normal.

Ordinary hazard bubbles can be requested for the decode and execute registers. These bubbles carry a dedicated bubble code that never raises an exception.

Top module: `pipe_exc_ctrl`

## Requirements
- R1: Reset (synchronous, active high) loads the bubble code into the decode, execute, memory and writeback status registers. Status codes are 3 bits: bubble=0, normal=1, halt=2, bad address=3, illegal instruction=4. While all stages hold bubbles, the processor status reads normal (1).
- R2: The decode status register loads the fetch classification, which follows this priority:
  - instruction memory error gives bad address (3);
  - otherwise an invalid instruction gives illegal (4);
  - otherwise a halt opcode gives halt (2);
  - otherwise the result is normal (1).

  When the decode bubble request is high, the register loads bubble (0) instead.
- R3: The execute status register loads the decode status unchanged, or bubble (0) when the execute bubble request is high. A hazard bubble never makes the processor status leave normal.
- R4: The updated memory-stage status is bad address (3) when the data memory error flag is high, and the memory-stage status otherwise. The writeback status register loads this updated status on the next clock unless writeback is stalled.
- R5: The processor status output equals normal (1) when the writeback status is bubble (0), and equals the writeback status otherwise.
- R6: The condition-code write enable is high exactly when the execute opcode equals the ALU opcode (default 6) and neither the updated memory-stage status nor the writeback status is halt, bad address or illegal.
- R7: The memory bubble request is high exactly when the updated memory-stage status or the writeback status is a fault code (2, 3 or 4). While it is high, the memory status register loads bubble (0) on the next clock instead of the execute status.
- R8: The writeback stall output is high exactly when the writeback status is a fault code. While stalled, the writeback status register keeps its value, so a fault in writeback persists until reset.
- R9: The data memory write enable equals the write request input only while the memory-stage status register holds normal (1); otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_err | input | 1 | Instruction fetch address fault |
| instr_bad | input | 1 | Fetched instruction code is not valid |
| halt_op | input | 1 | Fetched instruction is a halt |
| dmem_err | input | 1 | Data access fault for the instruction in memory |
| d_bubble | input | 1 | Hazard bubble request for the decode register |
| e_bubble | input | 1 | Hazard bubble request for the execute register |
| e_opcode | input | OPW | Opcode of the instruction in execute |
| mem_wr_req | input | 1 | Memory stage wants to write data memory |
| d_stat | output | 3 | Decode status register |
| e_stat | output | 3 | Execute status register |
| m_stat | output | 3 | Memory status register |
| w_stat | output | 3 | Writeback status register |
| cc_we | output | 1 | Condition-code write enable |
| m_bubble | output | 1 | Bubble request for the memory register |
| w_stall | output | 1 | Stall for the writeback register |
| dmem_we | output | 1 | Gated data memory write enable |
| cpu_stat | output | 3 | Architectural processor status |

## Verification
The hardest case to reach is a data memory fault arriving while an ALU operation sits in execute and a younger fetch fault is already travelling through decode. In that cycle the condition codes must be blocked, and the younger fault must be squashed and never reach writeback. A directed sequence lines up this collision stage by stage. Long stretches of random fault and bubble injection then follow, with a reset issued a few cycles after each fault freezes writeback, so that many distinct orderings of older and younger faults are exercised.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_BUB = 3'd0,
    ST_AOK = 3'd1,
    ST_HLT = 3'd2,
    ST_ADR = 3'd3,
    ST_INS = 3'd4
  } stat_t;

  // Status codes that stop the machine
  function automatic logic is_fault(stat_t s);
    return (s == ST_ADR) || (s == ST_INS) || (s == ST_HLT);
  endfunction
endpackage

// File: rtl/exc_fetch_class.sv
module exc_fetch_class
  import exc_pkg::*;
(
  input  logic  imem_err,
  input  logic  instr_bad,
  input  logic  halt_op,
  output stat_t f_st
);
  always_comb begin
    if (imem_err)       f_st = ST_ADR;
    else if (instr_bad) f_st = ST_INS;
    else if (halt_op)   f_st = ST_HLT;
    else                f_st = ST_AOK;
  end
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
  import exc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  flush,
  input  stat_t d,
  output stat_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= ST_BUB;
    end else if (!hold) begin
      q <= flush ? ST_BUB : d;
    end
  end
endmodule

// File: rtl/exc_side_gate.sv
module exc_side_gate
  import exc_pkg::*;
#(
  parameter int             OPW    = 4,
  parameter logic [OPW-1:0] OP_ALU = 'h6
)(
  input  stat_t          m_q,
  input  stat_t          w_q,
  input  logic           dmem_err,
  input  logic [OPW-1:0] e_opcode,
  input  logic           mem_wr_req,
  output stat_t          m_upd,
  output logic           cc_we,
  output logic           m_bubble,
  output logic           w_stall,
  output logic           dmem_we,
  output stat_t          cpu_stat
);
  logic m_fault, w_fault;

  always_comb begin
    m_upd    = dmem_err ? ST_ADR : m_q;
    m_fault  = is_fault(m_upd);
    w_fault  = is_fault(w_q);
    cc_we    = (e_opcode == OP_ALU) && !m_fault && !w_fault;
    m_bubble = m_fault || w_fault;
    w_stall  = w_fault;
    dmem_we  = mem_wr_req && (m_q == ST_AOK);
    cpu_stat = (w_q == ST_BUB) ? ST_AOK : w_q;
  end
endmodule

// File: rtl/pipe_exc_ctrl.sv
module pipe_exc_ctrl
  import exc_pkg::*;
#(
  parameter int             OPW    = 4,
  parameter logic [OPW-1:0] OP_ALU = 'h6
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           imem_err,
  input  logic           instr_bad,
  input  logic           halt_op,
  input  logic           dmem_err,
  input  logic           d_bubble,
  input  logic           e_bubble,
  input  logic [OPW-1:0] e_opcode,
  input  logic           mem_wr_req,
  output logic [2:0]     d_stat,
  output logic [2:0]     e_stat,
  output logic [2:0]     m_stat,
  output logic [2:0]     w_stat,
  output logic           cc_we,
  output logic           m_bubble,
  output logic           w_stall,
  output logic           dmem_we,
  output logic [2:0]     cpu_stat
);
  // Stage index: 0 decode, 1 execute, 2 memory, 3 writeback
  localparam int NSTG = 4;
  localparam int SD = 0, SE = 1, SM = 2, SW = 3;

  stat_t f_st, m_upd, cpu_st;
  stat_t sq [NSTG];
  stat_t sd [NSTG];
  logic  sh [NSTG];
  logic  sf [NSTG];

  exc_fetch_class u_fetch (
    .imem_err (imem_err),
    .instr_bad(instr_bad),
    .halt_op  (halt_op),
    .f_st     (f_st)
  );

  exc_side_gate #(.OPW(OPW), .OP_ALU(OP_ALU)) u_gate (
    .m_q       (sq[SM]),
    .w_q       (sq[SW]),
    .dmem_err  (dmem_err),
    .e_opcode  (e_opcode),
    .mem_wr_req(mem_wr_req),
    .m_upd     (m_upd),
    .cc_we     (cc_we),
    .m_bubble  (m_bubble),
    .w_stall   (w_stall),
    .dmem_we   (dmem_we),
    .cpu_stat  (cpu_st)
  );

  always_comb begin
    sd[SD] = f_st;   sh[SD] = 1'b0;    sf[SD] = d_bubble;
    sd[SE] = sq[SD]; sh[SE] = 1'b0;    sf[SE] = e_bubble;
    sd[SM] = sq[SE]; sh[SM] = 1'b0;    sf[SM] = m_bubble;
    sd[SW] = m_upd;  sh[SW] = w_stall; sf[SW] = 1'b0;
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    exc_stage_reg u_reg (
      .clk  (clk),
      .rst  (rst),
      .hold (sh[g]),
      .flush(sf[g]),
      .d    (sd[g]),
      .q    (sq[g])
    );
  end

  assign d_stat   = sq[SD];
  assign e_stat   = sq[SE];
  assign m_stat   = sq[SM];
  assign w_stat   = sq[SW];
  assign cpu_stat = cpu_st;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int             OPW    = 4,
  parameter logic [OPW-1:0] OP_ALU = 'h6
)(
  input logic           clk,
  input logic           rst,
  input logic           imem_err,
  input logic           dmem_err,
  input logic           d_bubble,
  input logic           e_bubble,
  input logic [OPW-1:0] e_opcode,
  input logic [2:0]     d_stat,
  input logic [2:0]     e_stat,
  input logic [2:0]     m_stat,
  input logic [2:0]     w_stat,
  input logic           cc_we,
  input logic           m_bubble,
  input logic           dmem_we,
  input logic [2:0]     cpu_stat
);
  function automatic logic flt(logic [2:0] s);
    return (s == 3'd2) || (s == 3'd3) || (s == 3'd4);
  endfunction

  a_r2_imem_first: assert property (@(posedge clk) disable iff (rst)
    (imem_err && !d_bubble) |=> (d_stat == 3'd3));

  a_r3_exec_pass: assert property (@(posedge clk) disable iff (rst)
    !e_bubble |=> (e_stat == $past(d_stat)));

  a_r4_dmem_adr: assert property (@(posedge clk) disable iff (rst)
    (dmem_err && !flt(w_stat)) |=> (w_stat == 3'd3));

  a_r5_bub_reads_ok: assert property (@(posedge clk) disable iff (rst)
    (w_stat == 3'd0) |-> (cpu_stat == 3'd1));

  a_r6_cc_blocked: assert property (@(posedge clk) disable iff (rst)
    cc_we |-> ((e_opcode == OP_ALU) && !flt(w_stat) && !dmem_err));

  a_r7_mem_squash: assert property (@(posedge clk) disable iff (rst)
    m_bubble |=> (m_stat == 3'd0));

  a_r8_wb_frozen: assert property (@(posedge clk) disable iff (rst)
    flt(w_stat) |=> $stable(w_stat));

  a_r9_write_ok_only: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (m_stat == 3'd1));
endmodule

bind pipe_exc_ctrl exc_ctrl_chk #(.OPW(OPW), .OP_ALU(OP_ALU)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .imem_err(imem_err),
  .dmem_err(dmem_err),
  .d_bubble(d_bubble),
  .e_bubble(e_bubble),
  .e_opcode(e_opcode),
  .d_stat  (d_stat),
  .e_stat  (e_stat),
  .m_stat  (m_stat),
  .w_stat  (w_stat),
  .cc_we   (cc_we),
  .m_bubble(m_bubble),
  .dmem_we (dmem_we),
  .cpu_stat(cpu_stat)
);

// File: tb/pipe_exc_ctrl_tb_top.sv
`timescale 1ns/1ps
module pipe_exc_ctrl_tb_top;
  localparam int OPW = 4;
  localparam logic [OPW-1:0] ALU = 4'h6;
  localparam int BUB = 0, AOK = 1, HLT = 2, ADR = 3, INS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic imem_err = 0, instr_bad = 0, halt_op = 0, dmem_err = 0;
  logic d_bubble = 0, e_bubble = 0, mem_wr_req = 0;
  logic [OPW-1:0] e_opcode = '0;
  logic [2:0] d_stat, e_stat, m_stat, w_stat, cpu_stat;
  logic cc_we, m_bubble, w_stall, dmem_we;

  int n_chk = 0, n_bad = 0;
  int pipe[4];  // model: 0 decode, 1 execute, 2 memory, 3 writeback
  bit done = 0;

  always #4 clk = ~clk;

  pipe_exc_ctrl #(.OPW(OPW), .OP_ALU(ALU)) dut_i (
    .clk(clk), .rst(rst), .imem_err(imem_err), .instr_bad(instr_bad),
    .halt_op(halt_op), .dmem_err(dmem_err), .d_bubble(d_bubble),
    .e_bubble(e_bubble), .e_opcode(e_opcode), .mem_wr_req(mem_wr_req),
    .d_stat(d_stat), .e_stat(e_stat), .m_stat(m_stat), .w_stat(w_stat),
    .cc_we(cc_we), .m_bubble(m_bubble), .w_stall(w_stall),
    .dmem_we(dmem_we), .cpu_stat(cpu_stat)
  );

  function automatic bit fault(int s);
    return s == HLT || s == ADR || s == INS;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // Drive at negedge, compare, then advance the model at posedge.
  task automatic step(bit ie, bit ib, bit ho, bit de, bit db, bit eb,
                      logic [OPW-1:0] op, bit wr);
    int fs, ms, nx[4];
    imem_err = ie; instr_bad = ib; halt_op = ho; dmem_err = de;
    d_bubble = db; e_bubble = eb; e_opcode = op; mem_wr_req = wr;
    #1;
    fs = ie ? ADR : ib ? INS : ho ? HLT : AOK;
    ms = de ? ADR : pipe[2];
    chk("R2 decode status", d_stat, pipe[0]);
    chk("R3 execute status", e_stat, pipe[1]);
    chk("R7 memory status", m_stat, pipe[2]);
    chk("R4 writeback status", w_stat, pipe[3]);
    chk("R5 processor status", cpu_stat, (pipe[3] == BUB) ? AOK : pipe[3]);
    chk("R6 cc enable", cc_we, (op == ALU) && !fault(ms) && !fault(pipe[3]));
    chk("R7 mem bubble", m_bubble, fault(ms) || fault(pipe[3]));
    chk("R8 wb stall", w_stall, fault(pipe[3]));
    chk("R9 dmem write", dmem_we, wr && pipe[2] == AOK);
    nx[3] = fault(pipe[3]) ? pipe[3] : ms;
    nx[2] = (fault(ms) || fault(pipe[3])) ? BUB : pipe[1];
    nx[1] = eb ? BUB : pipe[0];
    nx[0] = db ? BUB : fs;
    @(posedge clk);
    for (int i = 0; i < 4; i++) pipe[i] = nx[i];
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk);
    for (int i = 0; i < 4; i++) pipe[i] = BUB;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset decode", d_stat, BUB);
    chk("R1 reset execute", e_stat, BUB);
    chk("R1 reset memory", m_stat, BUB);
    chk("R1 reset writeback", w_stat, BUB);
    chk("R1 reset status", cpu_stat, AOK);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, ALU, 1);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // Normal flow: ALU ops write codes, writes enabled once normal code reaches memory
    idle(8);
    // R2 halt fetched, freezes in writeback
    step(0, 0, 1, 0, 0, 0, ALU, 1);
    idle(10);
    chk("R8 halt persists", cpu_stat, HLT);
    do_reset();
    // R2 all three flags: bad address wins
    step(1, 1, 1, 0, 0, 0, 0, 0);
    idle(6);
    chk("R2 imem priority", cpu_stat, ADR);
    do_reset();
    // R2 invalid beats halt
    step(0, 1, 1, 0, 0, 0, 0, 0);
    idle(6);
    chk("R2 invalid priority", cpu_stat, INS);
    do_reset();
    // R6/R7: data fault with ALU in execute and a younger fetch fault in decode
    idle(3);
    step(0, 1, 0, 0, 0, 0, ALU, 0);
    step(0, 0, 0, 1, 0, 0, ALU, 1);
    idle(6);
    chk("R4 older data fault wins", cpu_stat, ADR);
    do_reset();
    // R3 hazard bubbles alone never raise a fault
    for (int i = 0; i < 40; i++)
      step(0, 0, 0, 0, $urandom_range(0, 1), $urandom_range(0, 1), 4'($urandom), 1);
    chk("R3 bubbles keep normal", cpu_stat, AOK);
    // Random fault injection
    begin
      int frozen = 0;
      for (int i = 0; i < 4000; i++) begin
        step(($urandom % 24) == 0, ($urandom % 24) == 0, ($urandom % 24) == 0,
             ($urandom % 24) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0,
             ($urandom % 3 == 0) ? ALU : 4'($urandom), $urandom_range(0, 1));
        if (fault(pipe[3])) frozen++;
        if (frozen > 4) begin
          frozen = 0;
          do_reset();
        end
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule